// File: doc/BRIEF.md
# Per-Second Resynchronised Sub-Step Tick Generator

This block splits each second into a fixed number of equal simulation sub-steps. A local tick enable (nominally 50 kHz) advances a tick counter. Every `TICKS_PER_STEP` ticks the counter emits a sub-step strobe and advances the sub-step index. After `STEPS_PER_SEC - 1` such local strobes the generator stops on its own. The final sub-step of every second is closed only by the externally validated second pulse. That pulse restarts the tick count on the same clock edge, without rounding to any coarser grid, so any offset at the start of a second is never carried into the next one.

The local oscillator drifts against the reference. All of that drift therefore lands in the last sub-step of each second and never adds up across seconds. At every second pulse the block reports the measured length of the step that just ended, minus the nominal step length, as a signed drift value.

A seconds counter is preset once, at start-up, from an integer-second value supplied from outside (any fractional part has already been dropped by the supplier). After that it advances by one on each second pulse.

Top module: `substep_gen`

## Requirements
- R1: While reset is asserted, `step_pulse`, `step_idx`, `sec_count` and `drift` are all zero. Until the first `sec_pulse` after reset, no strobe is emitted and `step_idx` stays 0 whatever `tick_en` does.
- R2: In the cycle after a `sec_pulse`, `step_pulse` is 1 and `step_idx` is 0. The tick count restarts from zero, and a tick enable present in the pulse cycle itself is not counted.
- R3: After a `sec_pulse`, each time `TICKS_PER_STEP` further enabled ticks have accumulated, `step_pulse` is 1 for one cycle and `step_idx` increments by one. This gives at most `STEPS_PER_SEC - 1` local strobes per second.
- R4: Once `step_idx` equals `STEPS_PER_SEC - 1`, no strobe is emitted and the index holds, however many ticks arrive, until the next `sec_pulse`.
- R5: Each `sec_pulse` without `sec_load` increments `sec_count` by one in the following cycle.
- R6: `sec_load` sets `sec_count` to `sec_value` in the following cycle. It takes priority over the increment from a simultaneous `sec_pulse`, which still restarts the sub-steps.
- R7: At every `sec_pulse` except the first after reset, `drift` becomes the two's complement value (ticks since the last strobe, saturated at `2*TICKS_PER_STEP-1`) minus `TICKS_PER_STEP`. It holds that value until the next `sec_pulse`, and it is negative when the pulse arrives early.
- R8: A cycle with `tick_en` low and no `sec_pulse` emits no strobe and leaves `step_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Local time-base tick, one cycle wide |
| sec_pulse | input | 1 | Validated once-per-second pulse |
| sec_load | input | 1 | Preset strobe for the seconds counter |
| sec_value | input | SEC_W | Integer seconds to preset |
| step_pulse | output | 1 | Sub-step boundary strobe |
| step_idx | output | $clog2(STEPS_PER_SEC) | Sub-step index within the second |
| sec_count | output | SEC_W | Seconds counter |
| drift | output | $clog2(2*TICKS_PER_STEP)+1 | Signed final-step length error in ticks |

## Verification
The bench builds the block with 8 ticks per step, 5 steps per second and a 16-bit seconds counter. A full second then lasts about 40 enabled ticks, and the drift field is 5 bits with a saturation point of 15 ticks. With these values, dozens of whole seconds, early pulses, the saturated hold state and the signed drift extremes are all reached within a few thousand cycles, under both random and dense tick patterns.

// File: rtl/substep_gen.sv
module substep_gen #(
  parameter int TICKS_PER_STEP = 1000,
  parameter int STEPS_PER_SEC  = 50,
  parameter int SEC_W          = 32,
  localparam int IDX_W   = $clog2(STEPS_PER_SEC),
  localparam int CNT_W   = $clog2(2 * TICKS_PER_STEP),
  localparam int DRIFT_W = CNT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  input  logic                      sec_pulse,
  input  logic                      sec_load,
  input  logic [SEC_W-1:0]          sec_value,
  output logic                      step_pulse,
  output logic [IDX_W-1:0]          step_idx,
  output logic [SEC_W-1:0]          sec_count,
  output logic signed [DRIFT_W-1:0] drift
);

  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(STEPS_PER_SEC - 1);
  localparam logic [CNT_W-1:0]   STEP_END = CNT_W'(TICKS_PER_STEP - 1);
  localparam logic [CNT_W-1:0]   CNT_MAX  = CNT_W'(2 * TICKS_PER_STEP - 1);
  localparam logic [DRIFT_W-1:0] NOMINAL  = DRIFT_W'(TICKS_PER_STEP);

  logic             running;
  logic [CNT_W-1:0] cnt;

  wire at_last    = step_idx == LAST_IDX;
  wire local_fire = running && tick_en && !sec_pulse && !at_last && cnt == STEP_END;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cnt        <= '0;
      step_idx   <= '0;
      step_pulse <= 1'b0;
      drift      <= '0;
    end else begin
      step_pulse <= sec_pulse || local_fire;
      if (sec_pulse) begin
        running  <= 1'b1;
        cnt      <= '0;
        step_idx <= '0;
        if (running) drift <= $signed(DRIFT_W'(cnt) - NOMINAL);
      end else if (running && tick_en) begin
        if (local_fire) begin
          cnt      <= '0;
          step_idx <= step_idx + 1'b1;
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sec_count <= '0;
    else if (sec_load)  sec_count <= sec_value;
    else if (sec_pulse) sec_count <= sec_count + 1'b1;
  end

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> step_pulse && step_idx == '0);

  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= LAST_IDX);

  a_r4_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    at_last && !sec_pulse |=> !step_pulse && step_idx == LAST_IDX);

  a_r5_sec_inc: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !sec_load |=> sec_count == $past(sec_count) + 1'b1);

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    sec_load |=> sec_count == $past(sec_value));

  a_r7_drift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_pulse |=> $stable(drift));

  a_r8_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !sec_pulse |=> !step_pulse && $stable(step_idx));

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !sec_pulse |=> !step_pulse);

endmodule

// File: tb/substep_gen_test.sv
`timescale 1ns/1ps
module substep_gen_test;
  localparam int T    = 8;
  localparam int S    = 5;
  localparam int CMAX = 2 * T - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic tick_en = 0, sec_pulse = 0, sec_load = 0;
  logic [15:0] sec_value = '0;
  logic step_pulse;
  logic [2:0] step_idx;
  logic [15:0] sec_count;
  logic signed [4:0] drift;

  int checks = 0, failures = 0;
  bit done = 0;
  bit e_run = 0;
  int e_ticks = 0, e_drift = 0, e_sec = 0;

  substep_gen #(.TICKS_PER_STEP(T), .STEPS_PER_SEC(S), .SEC_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sec_pulse(sec_pulse),
    .sec_load(sec_load), .sec_value(sec_value), .step_pulse(step_pulse),
    .step_idx(step_idx), .sec_count(sec_count), .drift(drift));

  always #2.5 clk = ~clk;

  function automatic int idx_of(int ticks);
    return (ticks / T < S - 1) ? ticks / T : S - 1;
  endfunction

  function automatic int drift_of(int ticks);
    int rem = ticks - idx_of(ticks) * T;
    return ((rem > CMAX) ? CMAX : rem) - T;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit te, bit sp, bit ld, int val);
    bit fire = 0;
    string rq;
    tick_en = te; sec_pulse = sp; sec_load = ld; sec_value = 16'(val);
    @(negedge clk);
    if (sp) begin
      fire = 1;
      if (e_run) e_drift = drift_of(e_ticks);
      e_run = 1; e_ticks = 0;
    end else if (e_run && te) begin
      e_ticks++;
      if (e_ticks % T == 0 && e_ticks / T <= S - 1) fire = 1;
    end
    if (ld) e_sec = val & 16'hffff;
    else if (sp) e_sec = (e_sec + 1) & 16'hffff;
    if (!e_run) rq = "R1";
    else if (sp) rq = "R2";
    else if (!te) rq = "R8";
    else if (e_ticks > (S - 1) * T) rq = "R4";
    else rq = "R3";
    check(rq, int'(step_pulse), int'(fire), "step_pulse");
    check(rq, int'(step_idx), e_run ? idx_of(e_ticks) : 0, "step_idx");
    check(ld ? "R6" : "R5", int'(sec_count), e_sec, "sec_count");
    check("R7", int'(drift), e_drift, "drift");
  endtask

  task automatic second(int n, int tick_pct);
    cyc(($urandom % 100) < tick_pct, 1, 0, 0);
    for (int i = 0; i < n; i++) cyc(($urandom % 100) < tick_pct, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    @(negedge clk);
    @(negedge clk);
    check("R1", int'(step_pulse), 0, "reset step_pulse");
    check("R1", int'(step_idx), 0, "reset step_idx");
    check("R1", int'(sec_count), 0, "reset sec_count");
    check("R1", int'(drift), 0, "reset drift");
    rst_n = 1;
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 1234);
    second(S * T, 100);
    second(S * T, 100);
    second(S * T + 3, 100);
    second(2 * T + 3, 100);
    second(60, 100);
    second(S * T - 1, 100);
    cyc(1, 1, 1, 500);
    for (int i = 0; i < S * T; i++) cyc(1, 0, 0, 0);
    second(S * T + 5, 100);
    second(S * T, 0);
    for (int k = 0; k < 25; k++) second(S * T - 4 + int'($urandom % 10), 100);
    for (int k = 0; k < 25; k++) second(S * T + int'($urandom % 20), 75);
    for (int k = 0; k < 10; k++) second(int'($urandom % (3 * S * T)), 60);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule